// File: doc/BRIEF.md
# Grouped External Interrupt Controller

The block watches sixteen asynchronous external interrupt pins. Each pin first passes through a two-flop synchronizer. A detector then checks it against a programmable trigger condition: a level, a single edge or both edges. Adjacent pins 2k and 2k+1 share one 3-bit trigger field.

Detected events are latched in a pending register and gated by a per-line mask. The active lines are merged into three request outputs that cover uneven groups: lines 0-3, lines 4-11 and lines 12-15. A host interrupt controller takes these outputs. Software programs the block through a small register port: it sets trigger fields and the mask, and it acknowledges events with write-one-to-clear.

Top module: `eint_group_ctrl`

## Requirements
- R1: After reset the mask register (offset 0x20) reads 0xFFFF, the pending register (offset 0x24) reads 0, the trigger register (offset 0x00) reads 0 and `irq_o` is 0. The synchronizer and the previous-value flops reset to logic high.
- R2: A pin change made between clock edges first shows in the pending register after the third following rising clock edge, and not after the second.
- R3: Trigger code 3'b100 detects only rising edges, 3'b010 only falling edges, and 3'b110 or 3'b111 detects both edges.
- R4: Code 3'b000 is active-low level and 3'b001 is active-high level. While the level persists, the pending bit is set again on every cycle, so an acknowledge does not clear it. Once the pin is inactive, an acknowledge clears it.
- R5: Codes 3'b011 and 3'b101 disable detection for both lines of the pair.
- R6: The trigger field for line n is at bits [(n/2)*4+2:(n/2)*4] of offset 0x00 and controls lines 2k and 2k+1 together. Bit 3 of each nibble is not stored and reads 0.
- R7: A mask bit at 1 (offset 0x20, bit n) blocks line n from `irq_o`, but the line's pending bit is still recorded.
- R8: Writing 1 to bit n of offset 0x24 clears pending bit n, and writing 0 leaves it unchanged. An event in the same cycle as the clear leaves the bit set.
- R9: `irq_o[0]` is the OR of unmasked pending lines 0-3, `irq_o[1]` covers lines 4-11 and `irq_o[2]` covers lines 12-15.
- R10: Reads of any offset other than 0x00, 0x20 and 0x24 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Asynchronous external interrupt pins |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write enable for the access |
| reg_addr_i | input | 6 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 3 | Grouped interrupt requests |

## Verification
A corrupted pending bit shows on `irq_o` in the same cycle if its line is unmasked, and on a read of offset 0x24 in the cycle after the faulty edge. A wrong decode of a trigger field misses an event or adds one: the pending bit differs exactly three edges after the pin moves. An acknowledge that misbehaves is exposed on the first read after the write. A group boundary that is off by one shows as soon as a single line at the edge of a group is unmasked.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int unsigned NUM_LINES      = 16;
  localparam int unsigned LINES_PER_FLD  = 2;
  localparam int unsigned FIELD_W        = 3;
  localparam int unsigned FIELD_STRIDE   = 4;
  localparam int unsigned NUM_FIELDS     = NUM_LINES / LINES_PER_FLD;
  localparam int unsigned NUM_GROUPS     = 3;
  localparam int unsigned ADDR_W         = 6;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned SYNC_STAGES    = 2;

  localparam logic [ADDR_W-1:0] CFG_OFS  = 6'h00;
  localparam logic [ADDR_W-1:0] MASK_OFS = 6'h20;
  localparam logic [ADDR_W-1:0] PEND_OFS = 6'h24;

  typedef struct packed {
    logic lvl_low;
    logic lvl_high;
    logic edge_fall;
    logic edge_rise;
  } trig_t;

  function automatic trig_t decode_trig(input logic [FIELD_W-1:0] code);
    trig_t t;
    t = '0;
    casez (code)
      3'b000: t.lvl_low   = 1'b1;
      3'b001: t.lvl_high  = 1'b1;
      3'b010: t.edge_fall = 1'b1;
      3'b100: t.edge_rise = 1'b1;
      3'b11?: begin
        t.edge_rise = 1'b1;
        t.edge_fall = 1'b1;
      end
      default: t = '0;
    endcase
    return t;
  endfunction

  function automatic int unsigned grp_lo(input int unsigned g);
    case (g)
      0:       return 0;
      1:       return 4;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned grp_hi(input int unsigned g);
    case (g)
      0:       return 3;
      1:       return 11;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= {WIDTH{RST_VAL}};
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int unsigned WIDTH = NUM_LINES
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [WIDTH-1:0]              lvl_i,
  input  logic [WIDTH-1:0][FIELD_W-1:0] mode_i,
  output logic [WIDTH-1:0]              evt_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    trig_t tr;
    assign tr = decode_trig(mode_i[i]);
    assign evt_o[i] = (tr.lvl_low   & ~lvl_i[i])
                    | (tr.lvl_high  &  lvl_i[i])
                    | (tr.edge_rise &  lvl_i[i] & ~prev_q[i])
                    | (tr.edge_fall & ~lvl_i[i] &  prev_q[i]);

    // R3
    rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == 3'b100 && evt_o[i]) |-> (lvl_i[i] && !$past(lvl_i[i])));
    // R5
    disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == 3'b011 || mode_i[i] == 3'b101) |-> !evt_o[i]);
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              en_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  input  logic [NUM_LINES-1:0]              evt_i,
  output logic [NUM_LINES-1:0][FIELD_W-1:0] mode_o,
  output logic [NUM_LINES-1:0]              mask_o,
  output logic [NUM_LINES-1:0]              pend_o
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cfg_q;
  logic [NUM_LINES-1:0]               mask_q, pend_q, clr;
  logic [DATA_W-1:0]                  cfg_word;
  logic                               wr_cfg, wr_mask, wr_pend;
  logic [NUM_FIELDS-1:0]              unused_gap;

  assign wr_cfg  = en_i && we_i && (addr_i == CFG_OFS);
  assign wr_mask = en_i && we_i && (addr_i == MASK_OFS);
  assign wr_pend = en_i && we_i && (addr_i == PEND_OFS);
  assign clr     = wr_pend ? wdata_i[NUM_LINES-1:0] : '0;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[k] <= '0;
      else if (wr_cfg) cfg_q[k] <= wdata_i[k*FIELD_STRIDE +: FIELD_W];
    end
    assign unused_gap[k] = wdata_i[k*FIELD_STRIDE + FIELD_W];
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_map
    assign mode_o[n] = cfg_q[n / LINES_PER_FLD];
  end

  always_comb begin
    cfg_word = '0;
    for (int k = 0; k < NUM_FIELDS; k++)
      cfg_word[k*FIELD_STRIDE +: FIELD_W] = cfg_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (wr_mask) mask_q <= wdata_i[NUM_LINES-1:0];
  end

  // event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | evt_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      CFG_OFS:  rdata_o = cfg_word;
      MASK_OFS: rdata_o[NUM_LINES-1:0] = mask_q;
      PEND_OFS: rdata_o[NUM_LINES-1:0] = pend_q;
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
    // R8
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[n] && !(wr_pend && wdata_i[n])) |=> pend_q[n]);
    // R4
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[n] |=> pend_q[n]);
  end
endmodule

// File: rtl/eint_group_ctrl.sv
module eint_group_ctrl
  import eint_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  pin_i,
  input  logic                  reg_en_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [NUM_LINES-1:0]              lvl, evt, mask, pend, active;
  logic [NUM_LINES-1:0][FIELD_W-1:0] mode;

  eint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  eint_detect #(.WIDTH(NUM_LINES)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .mode_i(mode),
    .evt_o (evt)
  );

  eint_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (reg_en_i),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .evt_i  (evt),
    .mode_o (mode),
    .mask_o (mask),
    .pend_o (pend)
  );

  assign active = pend & ~mask;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = grp_lo(g);
    localparam int unsigned HI = grp_hi(g);
    assign irq_o[g] = |active[HI:LO];
  end

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|pend));
  // R7
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> (irq_o == '0));
endmodule

// File: tb/tb_eint_group_ctrl.sv
module tb_eint_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = 16'hFFFF;
  logic        en = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  eint_group_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_en_i(en), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h20, v); chk("R1 mask", v, 32'h0000FFFF);
    rd(6'h24, v); chk("R1 pend", v, 32'h0);
    rd(6'h00, v); chk("R1 cfg", v, 32'h0);
    chk("R1 irq", {29'b0, irq}, 32'h0);
    rd(6'h10, v); chk("R10 unmapped", v, 32'h0);
    rd(6'h3C, v); chk("R10 unmapped hi", v, 32'h0);
  endtask

  task automatic t_cfg_map;
    logic [31:0] v;
    wr(6'h00, 32'hFFFFFFFF);
    rd(6'h00, v); chk("R6 gap bits", v, 32'h77777777);
    wr(6'h00, 32'h0);
    rd(6'h00, v); chk("R6 cleared", v, 32'h0);
  endtask

  task automatic t_rising;
    logic [31:0] v;
    wr(6'h00, 32'h00000004);
    pin[0] = 1'b0; tick(5);
    rd(6'h24, v); chk("R3 rise ignores fall", v & 32'h3, 32'h0);
    wr(6'h24, 32'hFFFF);
    pin[0] = 1'b1;
    tick(2); rd(6'h24, v); chk("R2 not yet", v & 32'h1, 32'h0);
    tick(1); rd(6'h24, v); chk("R2 third edge", v & 32'h1, 32'h1);
    pin[1] = 1'b0; tick(4); pin[1] = 1'b1; tick(4);
    rd(6'h24, v); chk("R6 pair shares field", v & 32'h3, 32'h3);
    wr(6'h24, 32'hFFFF);
  endtask

  task automatic t_falling;
    logic [31:0] v;
    wr(6'h00, 32'h00000020);
    wr(6'h24, 32'hFFFF);
    pin[2] = 1'b0; tick(4);
    rd(6'h24, v); chk("R3 falling", v & 32'hC, 32'h4);
    wr(6'h24, 32'hFFFF);
    pin[2] = 1'b1; tick(4);
    rd(6'h24, v); chk("R3 fall ignores rise", v & 32'hC, 32'h0);
  endtask

  task automatic t_both;
    logic [31:0] v;
    wr(6'h00, 32'h00007600);
    wr(6'h24, 32'hFFFF);
    pin[4] = 1'b0; tick(4);
    rd(6'h24, v); chk("R3 both fall", v & 32'hF0, 32'h10);
    wr(6'h24, 32'hFFFF);
    pin[4] = 1'b1; tick(4);
    rd(6'h24, v); chk("R3 both rise", v & 32'hF0, 32'h10);
    wr(6'h24, 32'hFFFF);
    pin[6] = 1'b0; tick(4); pin[6] = 1'b1; tick(4);
    rd(6'h24, v); chk("R3 code 111", v & 32'hF0, 32'h40);
    wr(6'h24, 32'hFFFF);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(6'h00, 32'h00010000);
    tick(2);
    rd(6'h24, v); chk("R4 high level", v & 32'h300, 32'h300);
    wr(6'h24, 32'h0100);
    rd(6'h24, v); chk("R8 event wins clear", v & 32'h100, 32'h100);
    pin[8] = 1'b0; pin[9] = 1'b0; tick(4);
    wr(6'h24, 32'h0300);
    rd(6'h24, v); chk("R4 high cleared", v & 32'h300, 32'h0);
    pin[8] = 1'b1; pin[9] = 1'b1; tick(3);
    wr(6'h24, 32'hFFFF);
    pin[10] = 1'b0; tick(4);
    rd(6'h24, v); chk("R4 low level", v & 32'h400, 32'h400);
    wr(6'h24, 32'h0400);
    rd(6'h24, v); chk("R4 low held", v & 32'h400, 32'h400);
    pin[10] = 1'b1; tick(4);
    wr(6'h24, 32'h0400);
    rd(6'h24, v); chk("R4 low cleared", v & 32'h400, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(6'h00, 32'h53000000);
    wr(6'h24, 32'hFFFF);
    pin[12] = 1'b0; pin[15] = 1'b0; tick(4);
    pin[12] = 1'b1; pin[15] = 1'b1; tick(4);
    rd(6'h24, v); chk("R5 disabled codes", v & 32'hF000, 32'h0);
  endtask

  task automatic t_groups;
    logic [31:0] v;
    wr(6'h00, 32'h11111111);
    tick(3);
    rd(6'h24, v); chk("R7 pend while masked", v, 32'hFFFF);
    chk("R7 all masked", {29'b0, irq}, 32'h0);
    wr(6'h20, 32'hFFF7); chk("R9 line3", {29'b0, irq}, 32'h1);
    wr(6'h20, 32'hFFEF); chk("R9 line4", {29'b0, irq}, 32'h2);
    wr(6'h20, 32'hF7FF); chk("R9 line11", {29'b0, irq}, 32'h2);
    wr(6'h20, 32'hEFFF); chk("R9 line12", {29'b0, irq}, 32'h4);
    wr(6'h20, 32'h7FFF); chk("R9 line15", {29'b0, irq}, 32'h4);
    wr(6'h20, 32'hEFFE); chk("R9 lines0,12", {29'b0, irq}, 32'h5);
    wr(6'h20, 32'hFFFF);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(6'h00, 32'h44444444);
    wr(6'h24, 32'hFFFF);
    rd(6'h24, v); chk("R8 all cleared", v, 32'h0);
    pin[0] = 1'b0; tick(3); pin[0] = 1'b1; tick(4);
    wr(6'h24, 32'h0000);
    rd(6'h24, v); chk("R8 zero write", v, 32'h1);
    wr(6'h24, 32'hFFFE);
    rd(6'h24, v); chk("R8 other bits", v, 32'h1);
    wr(6'h24, 32'h0001);
    rd(6'h24, v); chk("R8 w1c", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_cfg_map();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_disabled();
    t_groups();
    t_w1c();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule